// File: doc/BRIEF.md
# Store Data Lane Merger

This block sits on the store path of a 64-bit little-endian core. For each store request it forms the effective address from a base register and a signed 16-bit offset, aligns it to the access size, and builds the complete doubleword that memory should receive. Source bytes are placed into their lanes, and the untouched bytes are taken from the doubleword currently held at the aligned address. An 8-bit byte-enable marks which lanes carry new data.

Byte, halfword, word and doubleword stores are supported. Two partial unaligned doubleword stores are also supported: a left form that writes the upper part of the source into the low lanes up to the addressed byte, and a right form that writes the low part of the source into the lanes from the addressed byte upward. Results are registered and are announced by a one-cycle valid strobe.

Top module: `store_merge`

## Requirements
- R1: The effective address is `base_i` plus `imm_i` sign-extended to 64 bits.
- R2: `addr_o` is the effective address with bits cleared according to the opcode: none for a byte store (op 0), bit 0 for a halfword (op 1), bits 1:0 for a word (op 2), and bits 2:0 for a doubleword (op 3), a left partial store (op 4) and a right partial store (op 5).
- R3: A byte store (op 0) enables only lane a = ea[2:0] and writes `src_i[7:0]` into that lane.
- R4: A halfword store (op 1) enables lanes L and L+1 with L = ea[2:1]*2, and writes `src_i[15:0]` there, low byte in lane L.
- R5: A word store (op 2) enables lanes L..L+3 with L = ea[2]*4, and writes `src_i[31:0]` there, low byte in lane L.
- R6: A doubleword store (op 3) enables all eight lanes and writes `src_i` unchanged.
- R7: For a left partial store (op 4), with s = 8*(7-a) and m = all-ones >> s, the write data is ((src >> s) & m) | (old & ~m), and `be_o` bit i is set exactly when byte i of m is all ones (lanes 0..a).
- R8: For a right partial store (op 5), with s = 8*a and m = all-ones << s, the write data is ((src << s) & m) | (old & ~m), and `be_o` bit i is set exactly when byte i of m is all ones (lanes a..7).
- R9: Every lane that `be_o` does not enable carries the matching byte of `old_i` in `wdata_o`.
- R10: A request with `req_valid_i` high and op 0 to 5 produces `valid_o` high for exactly one cycle, one clock after the request. Requests with op 6 or 7, and cycles with `req_valid_i` low, leave `valid_o` low and hold `addr_o`, `wdata_o` and `be_o` unchanged.
- R11: While `rst_ni` is low, `valid_o`, `addr_o`, `wdata_o` and `be_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Store request present |
| op_i | input | 3 | Store opcode (0 byte, 1 half, 2 word, 3 dword, 4 left, 5 right) |
| base_i | input | 64 | Base register value |
| imm_i | input | 16 | Signed address offset |
| src_i | input | 64 | Source register value |
| old_i | input | 64 | Current doubleword at the aligned address |
| valid_o | output | 1 | One-cycle result strobe |
| addr_o | output | 64 | Aligned write address |
| wdata_o | output | 64 | Merged write doubleword |
| be_o | output | 8 | Byte-enable, bit i for lane i |

## Verification
A wrong lane offset or shift amount appears in the cycle after the request. It shows as a misplaced source byte or a `be_o` pattern that is off by one lane, and it usually breaks both the enabled lanes and the preserved lanes at once. A stale or wrongly gated result register shows up as an extra or missing `valid_o` pulse, or as outputs that change after an ignored opcode. The sweep covers every opcode, every low address value and several data patterns, so each of these faults is caught within one request.

// File: rtl/store_merge_pkg.sv
package store_merge_pkg;

  typedef enum logic [2:0] {
    ST_BYTE  = 3'd0,
    ST_HALF  = 3'd1,
    ST_WORD  = 3'd2,
    ST_DWORD = 3'd3,
    ST_LEFT  = 3'd4,
    ST_RIGHT = 3'd5,
    ST_RSV6  = 3'd6,
    ST_RSV7  = 3'd7
  } st_op_e;

  function automatic logic op_legal(st_op_e op);
    return (op != ST_RSV6) && (op != ST_RSV7);
  endfunction

  // log2 of the access size in bytes; partial stores span a full doubleword
  function automatic int size_log2(st_op_e op);
    case (op)
      ST_BYTE: return 0;
      ST_HALF: return 1;
      ST_WORD: return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/store_ea.sv
module store_ea
  import store_merge_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int OFF_W = 3
) (
  input  st_op_e            op_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [XLEN-1:0]   addr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [OFF_W-1:0]  lane_o
);

  logic [XLEN-1:0]  imm_ext;
  logic [XLEN-1:0]  ea;
  logic [OFF_W-1:0] clr;

  assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign ea      = base_i + imm_ext;

  always_comb begin
    clr = '0;
    for (int b = 0; b < OFF_W; b++) begin
      if (b < size_log2(op_i)) clr[b] = 1'b1;
    end
  end

  assign off_o  = ea[OFF_W-1:0];
  assign lane_o = ea[OFF_W-1:0] & ~clr;
  assign addr_o = {ea[XLEN-1:OFF_W], lane_o};

endmodule

// File: rtl/store_lane_mask.sv
module store_lane_mask
  import store_merge_pkg::*;
#(
  parameter int NB    = 8,
  parameter int OFF_W = 3
) (
  input  st_op_e           op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] lane_i,
  output logic [NB-1:0]    be_o
);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic hit;
    int   span;

    always_comb begin
      span = 1 << size_log2(op_i);
      case (op_i)
        ST_LEFT:  hit = (OFF_W'(i) <= off_i);
        ST_RIGHT: hit = (OFF_W'(i) >= off_i);
        ST_BYTE, ST_HALF, ST_WORD, ST_DWORD:
          hit = (i >= int'(lane_i)) && (i < int'(lane_i) + span);
        default:  hit = 1'b0;
      endcase
    end

    assign be_o[i] = hit;
  end

endmodule

// File: rtl/store_data_merge.sv
module store_data_merge
  import store_merge_pkg::*;
#(
  parameter int NB    = 8,
  parameter int OFF_W = 3
) (
  input  st_op_e            op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [NB*8-1:0]   src_i,
  input  logic [NB*8-1:0]   old_i,
  input  logic [NB-1:0]     be_i,
  output logic [NB*8-1:0]   wdata_o
);

  localparam int XLEN = NB * 8;
  localparam int SH_W = OFF_W + 3;

  logic [SH_W-1:0] shr_amt;
  logic [SH_W-1:0] shl_amt;
  logic [XLEN-1:0] src_shr;
  logic [XLEN-1:0] src_shl;

  assign shr_amt = {OFF_W'(NB - 1) - off_i, 3'b000};
  assign shl_amt = {off_i, 3'b000};
  assign src_shr = src_i >> shr_amt;
  assign src_shl = src_i << shl_amt;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] nb;
    int         idx;

    always_comb begin
      // narrow stores: lane i takes source byte (i mod size)
      idx = i & ((1 << size_log2(op_i)) - 1);
      case (op_i)
        ST_LEFT:  nb = src_shr[8*i +: 8];
        ST_RIGHT: nb = src_shl[8*i +: 8];
        default:  nb = src_i[8*idx +: 8];
      endcase
    end

    assign wdata_o[8*i +: 8] = be_i[i] ? nb : old_i[8*i +: 8];
  end

endmodule

// File: rtl/store_merge.sv
module store_merge
  import store_merge_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        op_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN-1:0]   old_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   addr_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic [XLEN/8-1:0] be_o
);

  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  st_op_e           op;
  logic             accept;
  logic [XLEN-1:0]  addr_d;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] lane;
  logic [NB-1:0]    be_d;
  logic [XLEN-1:0]  wdata_d;

  assign op     = st_op_e'(op_i);
  assign accept = req_valid_i && op_legal(op);

  store_ea #(
    .XLEN (XLEN),
    .IMM_W(IMM_W),
    .OFF_W(OFF_W)
  ) u_ea (
    .op_i  (op),
    .base_i(base_i),
    .imm_i (imm_i),
    .addr_o(addr_d),
    .off_o (off),
    .lane_o(lane)
  );

  store_lane_mask #(
    .NB   (NB),
    .OFF_W(OFF_W)
  ) u_mask (
    .op_i  (op),
    .off_i (off),
    .lane_i(lane),
    .be_o  (be_d)
  );

  store_data_merge #(
    .NB   (NB),
    .OFF_W(OFF_W)
  ) u_merge (
    .op_i   (op),
    .off_i  (off),
    .src_i  (src_i),
    .old_i  (old_i),
    .be_i   (be_d),
    .wdata_o(wdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      be_o    <= '0;
    end else begin
      valid_o <= accept;
      if (accept) begin
        addr_o  <= addr_d;
        wdata_o <= wdata_d;
        be_o    <= be_d;
      end
    end
  end

endmodule

// File: rtl/store_merge_chk.sv
module store_merge_chk #(
  parameter int XLEN = 64,
  parameter int NB   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] old_i,
  input logic            valid_o,
  input logic [XLEN-1:0] addr_o,
  input logic [XLEN-1:0] wdata_o,
  input logic [NB-1:0]   be_o
);

  localparam int OFF_W = $clog2(NB);

  function automatic logic [XLEN-1:0] expand(logic [NB-1:0] be);
    logic [XLEN-1:0] m;
    for (int i = 0; i < NB; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  logic req_ok;
  assign req_ok = req_valid_i && (op_i < 3'd6);

  assert_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> valid_o);

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ok |=> (!valid_o && $stable(wdata_o) && $stable(be_o) && $stable(addr_o)));

  assert_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5))
      |=> (addr_o[OFF_W-1:0] == '0));

  assert_keep_old_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> (((wdata_o ^ $past(old_i)) & ~expand(be_o)) == '0));

  assert_byte_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd0) |=> ($countones(be_o) == 1));

  assert_dword_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd3) |=> (be_o == '1));

  assert_left_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd4) |=> be_o[0]);

  assert_right_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd5) |=> be_o[NB-1]);

endmodule

bind store_merge store_merge_chk #(
  .XLEN(XLEN),
  .NB  (NB)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .op_i       (op_i),
  .old_i      (old_i),
  .valid_o    (valid_o),
  .addr_o     (addr_o),
  .wdata_o    (wdata_o),
  .be_o       (be_o)
);

// File: tb/sim_store_merge.sv
`timescale 1ns/1ps
module sim_store_merge;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] old_i = '0;
  logic        valid_o;
  logic [63:0] addr_o;
  logic [63:0] wdata_o;
  logic [7:0]  be_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  store_merge u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .op_i       (op_i),
    .base_i     (base_i),
    .imm_i      (imm_i),
    .src_i      (src_i),
    .old_i      (old_i),
    .valid_o    (valid_o),
    .addr_o     (addr_o),
    .wdata_o    (wdata_o),
    .be_o       (be_o)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R3 R9";
      1: return "R4 R9";
      2: return "R5 R9";
      3: return "R6 R9";
      4: return "R7 R9";
      default: return "R8 R9";
    endcase
  endfunction

  // arithmetic model of one store
  task automatic model(input int op, input logic [63:0] ea, input logic [63:0] src, input logic [63:0] old,
                       output logic [63:0] addr, output logic [63:0] data, output logic [7:0] be);
    int a;
    int n;
    int lane;
    int sh;
    logic [63:0] m;
    a = int'(ea[2:0]);
    be = '0;
    if (op <= 3) begin
      n = 1 << op;
      lane = a - (a % n);
      addr = ea - 64'(a % n);
      data = old;
      for (int i = 0; i < 8; i++) begin
        if (i >= lane && i < lane + n) begin
          be[i] = 1'b1;
          data[8*i +: 8] = src[8*(i-lane) +: 8];
        end
      end
    end else begin
      addr = {ea[63:3], 3'b000};
      if (op == 4) begin
        sh = 8 * (7 - a);
        m = 64'hFFFF_FFFF_FFFF_FFFF >> sh;
        data = ((src >> sh) & m) | (old & ~m);
      end else begin
        sh = 8 * a;
        m = 64'hFFFF_FFFF_FFFF_FFFF << sh;
        data = ((src << sh) & m) | (old & ~m);
      end
      for (int i = 0; i < 8; i++) be[i] = (m[8*i +: 8] == 8'hFF);
    end
  endtask

  task automatic drive(input logic v, input int op, input logic [63:0] base, input logic [15:0] imm,
                       input logic [63:0] src, input logic [63:0] old);
    @(negedge clk_i);
    req_valid_i = v;
    op_i = 3'(op);
    base_i = base;
    imm_i = imm;
    src_i = src;
    old_i = old;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  logic [63:0] SRC [3];
  logic [63:0] OLD [3];
  logic [15:0] IMM [3];

  initial begin
    logic [63:0] ea, e_addr, e_data, last_data, last_addr;
    logic [7:0]  e_be, last_be;
    SRC[0] = 64'h8877_6655_4433_2211; OLD[0] = 64'hDEAD_BEEF_CAFE_F00D; IMM[0] = 16'h0000;
    SRC[1] = 64'hF0E1_D2C3_B4A5_9687; OLD[1] = 64'h0000_0000_0000_0000; IMM[1] = 16'h8008;
    SRC[2] = 64'h0123_4567_89AB_CDEF; OLD[2] = 64'hFFFF_FFFF_FFFF_FFFF; IMM[2] = 16'h7FF8;

    repeat (3) @(negedge clk_i);
    chk("R11", "valid in reset", 64'(valid_o), 64'd0);
    chk("R11", "wdata in reset", wdata_o, 64'd0);
    chk("R11", "addr in reset", addr_o, 64'd0);
    chk("R11", "be in reset", 64'(be_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "valid after reset", 64'(valid_o), 64'd0);

    for (int op = 0; op < 6; op++) begin
      for (int a = 0; a < 8; a++) begin
        for (int p = 0; p < 3; p++) begin
          logic [63:0] base;
          base = 64'hA5A5_0000_1234_5670 + 64'(a) + 64'(p) * 64'h0000_0100_0000_0000;
          ea = base + {{48{IMM[p][15]}}, IMM[p]};
          model(op, ea, SRC[p], OLD[p], e_addr, e_data, e_be);
          drive(1'b1, op, base, IMM[p], SRC[p], OLD[p]);
          chk("R10", "valid strobe", 64'(valid_o), 64'd1);
          chk("R1 R2", "addr", addr_o, e_addr);
          chk(op_tag(op), "be", 64'(be_o), 64'(e_be));
          chk(op_tag(op), "wdata", wdata_o, e_data);
        end
      end
    end

    // strobe lasts one cycle
    @(negedge clk_i);
    chk("R10", "valid drops", 64'(valid_o), 64'd0);

    // ignored requests keep results
    model(3, 64'h0000_0000_0000_1000, 64'h1111_2222_3333_4444, 64'h0, last_addr, last_data, last_be);
    drive(1'b1, 3, 64'h0000_0000_0000_1000, 16'h0000, 64'h1111_2222_3333_4444, 64'h0);
    chk("R6", "wdata", wdata_o, last_data);
    for (int op = 6; op < 8; op++) begin
      drive(1'b1, op, 64'h0000_0000_0000_2003, 16'h0001, 64'hFFFF_0000_FFFF_0000, 64'h5555_5555_5555_5555);
      chk("R10", "valid reserved op", 64'(valid_o), 64'd0);
      chk("R10", "wdata hold reserved", wdata_o, last_data);
      chk("R10", "be hold reserved", 64'(be_o), 64'(last_be));
      chk("R10", "addr hold reserved", addr_o, last_addr);
    end
    drive(1'b0, 0, 64'h0000_0000_0000_3005, 16'h0000, 64'h77, 64'h0);
    chk("R10", "valid idle", 64'(valid_o), 64'd0);
    chk("R10", "wdata hold idle", wdata_o, last_data);
    chk("R10", "addr hold idle", addr_o, last_addr);

    // R1: negative offset crossing a large boundary
    model(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAB, 64'h0, e_addr, e_data, e_be);
    drive(1'b1, 0, 64'h0000_0000_0000_0000, 16'hFFFF, 64'hAB, 64'h0);
    chk("R1", "addr negative offset", addr_o, e_addr);
    chk("R3", "be top lane", 64'(be_o), 64'(e_be));

    // R11: asynchronous reset clears results
    #3 rst_ni = 1'b0;
    #2;
    chk("R11", "wdata on reset", wdata_o, 64'd0);
    chk("R11", "be on reset", 64'(be_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule